// File: doc/BRIEF.md
# Dual-Rail NULL-Convention Boolean Unit

This unit computes one of four Boolean functions (OR, AND, XOR, NOT) over variables carried on two rails each. A variable is a rail pair: the "zero" rail asserted means value 0, and the "one" rail asserted means value 1. Both rails low means NULL (no data). Both rails high is illegal and is never presented. A two-bit select picks the function. NOT uses only input A. The binary functions use A and B.

Every output rail comes from hysteresis threshold gates that see single rails, never whole variables. A threshold gate sets when at least M of its N inputs are high. It clears only when all of its inputs are low, and otherwise it keeps its value. Each gate is a clocked register, so the unit answers one clock after it samples its inputs. The rails of a binary function are built from four 2-of-2 gates, one for each pairing of an A rail with a B rail. Each output rail is the union of the pairings that give its value. NOT has no inverting gate: it passes the rails of A through 1-of-1 gates and swaps their labels.

Seen from outside, the output is DATA only once every variable in use carries data. It returns to NULL only once every variable in use is NULL. Inputs must alternate between DATA and NULL wavefronts: rails only rise during a DATA wavefront and only fall during a NULL wavefront.

Top module: `ncl_bool_unit`

## Requirements
- R1: One clock after reset is sampled low, both output rails are low.
- R2: With legal inputs, the two output rails are never high at the same time.
- R3: While the output is NULL, it stays NULL as long as any variable in use (A for NOT; both A and B otherwise) is NULL.
- R4: One clock after every variable in use carries data, the output carries data.
- R5: With select 0 (OR), the output value is A OR B.
- R6: With select 1 (AND), the output value is A AND B.
- R7: With select 2 (XOR), the output value is A XOR B.
- R8: With select 3 (NOT), the output zero rail follows the A one rail and the output one rail follows the A zero rail.
- R9: Once the output carries data, it holds that value unchanged until every variable in use is NULL, even after some of them have already returned to NULL.
- R10: One clock after every variable in use is NULL, the output is NULL.
- R11: With select 3, input B has no effect on the output.
- R12: The select may change only while both A and B are entirely NULL; inside a wavefront it is held.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock at which the threshold gates sample |
| rst_n | input | 1 | Synchronous active-low reset |
| sel | input | 2 | Function select: 0 OR, 1 AND, 2 XOR, 3 NOT |
| a_zero | input | 1 | Input A, value-0 rail |
| a_one | input | 1 | Input A, value-1 rail |
| b_zero | input | 1 | Input B, value-0 rail |
| b_one | input | 1 | Input B, value-1 rail |
| y_zero | output | 1 | Output, value-0 rail |
| y_one | output | 1 | Output, value-1 rail |

## Verification
Each binary function is tried with all four value pairs, so a term placed on the wrong output rail shows up as a wrong value in the truth table. Each pair is also presented twice, once with A arriving first and once with B first. The same pair is released in both orders as well. This tells apart a gate that fires early on a single rail from a correct 2-of-2 gate, and a gate that drops on partial NULL from one with true hysteresis. For NOT, both A values are applied while B is swept through NULL and both data values. This separates a pure rail swap from any path that leaks B.

// File: rtl/ncl_pkg.sv
// Package: shared function codes and the Boolean truth used to decide
// which rail-pairing term belongs to which output rail.
package ncl_pkg;

    typedef enum logic [1:0] {
        FN_OR  = 2'd0,
        FN_AND = 2'd1,
        FN_XOR = 2'd2,
        FN_NOT = 2'd3
    } ncl_fn_e;

    localparam int NUM_VALS  = 2;                    // values per variable
    localparam int NUM_TERMS = NUM_VALS * NUM_VALS;  // rail pairings

    // Value of a binary function for data values a and b (NOT ignores b).
    function automatic logic ncl_truth(ncl_fn_e f, logic a, logic b);
        case (f)
            FN_OR:   return a | b;
            FN_AND:  return a & b;
            FN_XOR:  return a ^ b;
            default: return ~a;
        endcase
    endfunction

endpackage

// File: rtl/ncl_th_gate.sv
// M-of-N threshold gate with hysteresis, as a clocked register.
// Sets when at least M inputs are high, clears only when none are high,
// and holds otherwise. Assumes inputs follow monotonic wavefronts.
module ncl_th_gate #(
    parameter int N = 2,
    parameter int M = N
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] x,
    output logic         q
);
    localparam int CW = $clog2(N + 1);

    logic [CW-1:0] cnt;

    // Count of asserted inputs.
    always_comb cnt = CW'($countones(x));

    // Threshold set, all-low clear, otherwise hold.
    always_ff @(posedge clk) begin
        if (!rst_n)
            q <= 1'b0;
        else if (cnt >= CW'(M))
            q <= 1'b1;
        else if (cnt == '0)
            q <= 1'b0;
    end
endmodule

// File: rtl/ncl_term_plane.sv
// Sub-variable gate plane: one 2-of-2 gate for each pairing of an A rail
// with a B rail, and a 1-of-1 gate on each A rail for the inversion path.
// Term index is {a value, b value}. Assumes legal (never both-high) inputs.
module ncl_term_plane
    import ncl_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_VALS-1:0]  a_rails,   // [v] = rail for value v
    input  logic [NUM_VALS-1:0]  b_rails,
    output logic [NUM_TERMS-1:0] terms,
    output logic [NUM_VALS-1:0]  a_held
);
    // Pairing gates: fire only when both chosen rails are DATA.
    for (genvar ia = 0; ia < NUM_VALS; ia++) begin : g_a
        for (genvar ib = 0; ib < NUM_VALS; ib++) begin : g_b
            ncl_th_gate #(.N(2), .M(2)) i_pair (
                .clk   (clk),
                .rst_n (rst_n),
                .x     ({b_rails[ib], a_rails[ia]}),
                .q     (terms[ia*NUM_VALS + ib])
            );
        end
    end

    // Single-rail buffers keep the inversion path at the same latency.
    for (genvar v = 0; v < NUM_VALS; v++) begin : g_buf
        ncl_th_gate #(.N(1), .M(1)) i_buf (
            .clk   (clk),
            .rst_n (rst_n),
            .x     (a_rails[v]),
            .q     (a_held[v])
        );
    end
endmodule

// File: rtl/ncl_rail_merge.sv
// Output rail assembly: each pairing term joins the rail for the value
// the selected function gives it; NOT just relabels the held A rails.
// Assumes the select is stable while any term is set.
module ncl_rail_merge
    import ncl_pkg::*;
(
    input  ncl_fn_e              fn,
    input  logic [NUM_TERMS-1:0] terms,
    input  logic [NUM_VALS-1:0]  a_held,
    output logic                 y_zero,
    output logic                 y_one
);
    // Union of terms per output value, or rail swap for inversion.
    always_comb begin
        y_zero = 1'b0;
        y_one  = 1'b0;
        if (fn == FN_NOT) begin
            y_zero = a_held[1];
            y_one  = a_held[0];
        end else begin
            for (int k = 0; k < NUM_TERMS; k++) begin
                if (ncl_truth(fn, k[1], k[0]))
                    y_one  = y_one  | terms[k];
                else
                    y_zero = y_zero | terms[k];
            end
        end
    end
endmodule

// File: rtl/ncl_bool_unit.sv
// Top: dual-rail NULL-convention Boolean unit. Output becomes DATA one
// clock after all variables in use are DATA, and NULL one clock after all
// are NULL. Assumes legal rails and a select changed only at full NULL.
module ncl_bool_unit
    import ncl_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] sel,
    input  logic       a_zero,
    input  logic       a_one,
    input  logic       b_zero,
    input  logic       b_one,
    output logic       y_zero,
    output logic       y_one
);
    logic [NUM_TERMS-1:0] terms;
    logic [NUM_VALS-1:0]  a_held;
    ncl_fn_e              fn;

    // Decode the select into the function code.
    always_comb fn = ncl_fn_e'(sel);

    ncl_term_plane i_plane (
        .clk     (clk),
        .rst_n   (rst_n),
        .a_rails ({a_one, a_zero}),
        .b_rails ({b_one, b_zero}),
        .terms   (terms),
        .a_held  (a_held)
    );

    ncl_rail_merge i_merge (
        .fn     (fn),
        .terms  (terms),
        .a_held (a_held),
        .y_zero (y_zero),
        .y_one  (y_one)
    );
endmodule

// File: rtl/ncl_bool_unit_chk.sv
// Checker for ncl_bool_unit: relates port behaviour across clocks.
// Assumes legal inputs and a select held inside each wavefront.
module ncl_bool_unit_chk
    import ncl_pkg::*;
(
    input logic       clk,
    input logic       rst_n,
    input logic [1:0] sel,
    input logic       a_zero,
    input logic       a_one,
    input logic       b_zero,
    input logic       b_one,
    input logic       y_zero,
    input logic       y_one
);
    logic is_not, a_data, b_data, all_data, all_null, y_null, y_data;
    logic rst_seen = 1'b0;

    // Completeness of the variables in use.
    always_comb begin
        is_not   = (sel == FN_NOT);
        a_data   = a_zero ^ a_one;
        b_data   = b_zero ^ b_one;
        all_data = is_not ? a_data : (a_data & b_data);
        all_null = is_not ? !(a_zero | a_one)
                          : !(a_zero | a_one | b_zero | b_one);
        y_null   = !(y_zero | y_one);
        y_data   = y_zero ^ y_one;
    end

    // Remember a sampled reset for the following edge.
    always_ff @(posedge clk) rst_seen <= !rst_n;

    // R1: outputs are low after a reset edge.
    always_ff @(posedge clk)
        if (rst_seen) assert_reset_null_R1: assert (!y_zero && !y_one);

    assert_rails_exclusive_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !(y_zero && y_one));

    assert_wait_complete_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (y_null && !all_data) |=> y_null);

    assert_data_after_complete_R4: assert property (@(posedge clk) disable iff (!rst_n)
        all_data |=> y_data);

    // R5 R6 R7 R8: value carried follows the selected function.
    assert_value_R5_R6_R7_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (all_data && $stable(sel)) |=> (y_one == ncl_truth(ncl_fn_e'($past(sel)),
                                                           $past(a_one), $past(b_one))));

    assert_hold_until_null_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (y_data && !all_null) |=> $stable({y_zero, y_one}));

    assert_null_after_null_R10: assert property (@(posedge clk) disable iff (!rst_n)
        all_null |=> y_null);
endmodule

bind ncl_bool_unit ncl_bool_unit_chk i_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .sel    (sel),
    .a_zero (a_zero),
    .a_one  (a_one),
    .b_zero (b_zero),
    .b_one  (b_one),
    .y_zero (y_zero),
    .y_one  (y_one)
);

// File: tb/test_ncl_bool_unit.sv
module test_ncl_bool_unit;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] sel = 2'd0;
    logic       a_zero = 1'b0, a_one = 1'b0, b_zero = 1'b0, b_one = 1'b0;
    logic       y_zero, y_one;
    int         checks = 0;
    int         failures = 0;
    bit         done = 1'b0;

    always #10ns clk = ~clk;   // 50 MHz

    ncl_bool_unit i_ncl_bool_unit (
        .clk(clk), .rst_n(rst_n), .sel(sel),
        .a_zero(a_zero), .a_one(a_one), .b_zero(b_zero), .b_one(b_one),
        .y_zero(y_zero), .y_one(y_one)
    );

    // Compare the output rail pair with an expected pair.
    task automatic chk(input string req, input logic [1:0] exp);
        checks++;
        if ({y_one, y_zero} !== exp) begin
            failures++;
            $display("FAIL %s: got one/zero=%b%b expected %b%b (sel=%0d)",
                     req, y_one, y_zero, exp[1], exp[0], sel);
        end
    endtask

    // Reference value for the tested function, written from the requirements.
    function automatic logic ref_val(logic [1:0] s, logic a, logic b);
        case (s)
            2'd0: return a || b;
            2'd1: return a && b;
            2'd2: return a != b;
            default: return !a;
        endcase
    endfunction

    // R1: reset state.
    task automatic t_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        chk("R1", 2'b00);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1", 2'b00);
    endtask

    // One DATA then NULL wavefront of a binary function; a_first picks order.
    task automatic t_binary(input logic [1:0] s, input logic av, input logic bv,
                            input bit a_first, input bit rel_a_first);
        logic [1:0] exp_data;
        exp_data = ref_val(s, av, bv) ? 2'b10 : 2'b01;
        sel = s;
        if (a_first) begin a_one = av; a_zero = !av; end
        else         begin b_one = bv; b_zero = !bv; end
        repeat (2) begin
            @(negedge clk);
            chk("R3", 2'b00);
        end
        if (a_first) begin b_one = bv; b_zero = !bv; end
        else         begin a_one = av; a_zero = !av; end
        @(negedge clk);
        // R4 and the function value: R5 OR, R6 AND, R7 XOR.
        case (s)
            2'd0: chk("R4/R5", exp_data);
            2'd1: chk("R4/R6", exp_data);
            default: chk("R4/R7", exp_data);
        endcase
        if ((y_zero && y_one) !== 1'b0) chk("R2", 2'b00);
        if (rel_a_first) begin a_one = 1'b0; a_zero = 1'b0; end
        else             begin b_one = 1'b0; b_zero = 1'b0; end
        repeat (2) begin
            @(negedge clk);
            chk("R9", exp_data);
        end
        a_one = 1'b0; a_zero = 1'b0; b_one = 1'b0; b_zero = 1'b0;
        @(negedge clk);
        chk("R10", 2'b00);
    endtask

    // NOT wavefront with B swept to show it is ignored.
    task automatic t_not(input logic av, input logic bv);
        logic [1:0] exp_data;
        exp_data = av ? 2'b01 : 2'b10;
        sel = 2'd3;
        b_one = bv; b_zero = !bv;
        @(negedge clk);
        chk("R11/R3", 2'b00);
        a_one = av; a_zero = !av;
        @(negedge clk);
        chk("R8", exp_data);
        b_one = 1'b0; b_zero = 1'b0;
        @(negedge clk);
        chk("R11", exp_data);
        b_one = !bv; b_zero = bv;
        @(negedge clk);
        chk("R11", exp_data);
        a_one = 1'b0; a_zero = 1'b0;
        @(negedge clk);
        chk("R10", 2'b00);
        b_one = 1'b0; b_zero = 1'b0;   // R12: full NULL before select changes
        @(negedge clk);
        chk("R10", 2'b00);
    endtask

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog: got running expected finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        @(negedge clk);
        t_reset();
        for (int s = 0; s < 3; s++)
            for (int v = 0; v < 4; v++)
                for (int ord = 0; ord < 2; ord++)
                    t_binary(2'(s), v[1], v[0], ord[0], !ord[0]);
        t_not(1'b0, 1'b0);
        t_not(1'b1, 1'b1);
        t_not(1'b1, 1'b0);
        t_binary(2'd2, 1'b1, 1'b1, 1'b1, 1'b1);
        t_reset();
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule